// File: doc/BRIEF.md
# Multiplexed Display RAM Write Packer

This block sits between a command decoder and the display side of a segment LCD controller. It takes a stream of display bytes and stores them in a bit RAM of 4 rows by 60 columns. Each column is the set of row bits for one segment output. The selected drive mode sets how a byte is cut into column words. In static mode a byte becomes eight 1-bit words. In 1:2 mode it becomes four 2-bit words, in 1:3 mode three 3-bit words, and in 1:4 mode two 4-bit words. A data pointer names the column where the next byte starts. After each byte the pointer moves forward by the number of columns that byte used.

Several devices can share one data stream in a cascade. Each device holds a 3-bit subaddress counter and compares it with its strapped 3-bit hardware subaddress. A device whose counter does not match stores nothing, but its pointer still advances. When the pointer runs past the last column, it wraps to zero and the counter steps to the next device. An input bank select moves static and 1:2 writes into the upper rows, so that a second image can be built there. A registered read port gives the display side one column at a time.

Top module: `dispram_packer`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, every RAM bit, the pointer, the subaddress counter, `rd_data` and `ovf` are zero.
- R2: Mode code 0 (static): byte bit 7-k is written to column p+k of the base row for k = 0..7, where p is the pointer. The pointer then grows by 8.
- R3: Mode code 1 (1:2): column p+j gets bit 7-2j in row base and bit 6-2j in row base+1, for j = 0..3. The pointer then grows by 4.
- R4: Mode code 2 (1:3): column p+j, row r gets bit 7-(3j+r) for j = 0..2 and r = 0..2. Row 2 of column p+2 is left unchanged. The pointer then grows by 3.
- R5: Mode code 3 (1:4): column p+j, row r gets bit 7-(4j+r) for j = 0..1 and r = 0..3. The pointer then grows by 2.
- R6: A byte is stored only when the subaddress counter equals `hw_sub`. On a mismatch the RAM is left unchanged, but the pointer still advances by the mode's step.
- R7: When pointer plus step reaches 60 or more, the pointer becomes 0 and the subaddress counter increments modulo 8, both at the same edge. `ovf` is high for exactly the following cycle. Bits that map to columns at or above 60 are dropped.
- R8: `ptr_load` loads the pointer from `ptr_value` and `sel_load` loads the counter from `sel_value`. A byte strobe in the same cycle as either command is ignored.
- R9: With `bank_in` = 1, the base row is 2 in modes 0 and 1 and 0 otherwise. With `bank_in` = 0, the base row is 0.
- R10: `abort` clears the pointer to 0 and discards any byte in the same cycle. It takes priority over `ptr_load`.
- R11: `rd_data` bit r is row r of column `rd_col` as it stood before the previous clock edge. Columns 60 to 63 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Drive mode code: 0 static, 1 1:2, 2 1:3, 3 1:4 |
| byte_vld | input | 1 | Display byte strobe |
| byte_data | input | 8 | Display byte |
| ptr_load | input | 1 | Load-pointer command |
| ptr_value | input | PTR_W | New pointer value |
| sel_load | input | 1 | Device-select command |
| sel_value | input | 3 | New subaddress counter value |
| bank_in | input | 1 | Input bank select |
| hw_sub | input | 3 | Hardware subaddress of this device |
| abort | input | 1 | Transfer aborted |
| rd_col | input | PTR_W | Read column |
| rd_data | output | 4 | Registered column contents, bit r is row r |
| ovf | output | 1 | One-cycle pointer wrap pulse |

## Verification
A strobe or command takes effect at the clock edge where it is sampled. At that edge the RAM, the pointer and the subaddress counter all update. `ovf` rises at the same edge, so it can be seen in the next cycle. `rd_data` adds one more register, so a column written at edge k appears on the read port after edge k+1. The bench drives and samples on falling edges. Its reference model updates at each rising edge and latches the read value from the RAM image as it stood before that edge's write. After each group of stimuli, the bench sweeps `rd_col` over all 64 codes, so every column, including the discarded range, is compared against the model.

// File: rtl/dpk_pkg.sv
// Shared types and mode helpers for the display RAM write packer.
// Assumes a RAM with four rows, which is the deepest drive mode.
package dpk_pkg;

    localparam int ROWS = 4;

    typedef enum logic [1:0] {
        MUX_STATIC = 2'd0,
        MUX_DUAL   = 2'd1,
        MUX_TRIPLE = 2'd2,
        MUX_QUAD   = 2'd3
    } mux_mode_e;

    // Number of rows one column word occupies in the given mode.
    function automatic logic [2:0] bits_per_col(mux_mode_e m);
        return 3'({1'b0, m}) + 3'd1;
    endfunction

    // Number of columns one byte spans, which is also the pointer step.
    function automatic logic [3:0] cols_per_byte(mux_mode_e m);
        case (m)
            MUX_STATIC: return 4'd8;
            MUX_DUAL:   return 4'd4;
            MUX_TRIPLE: return 4'd3;
            default:    return 4'd2;
        endcase
    endfunction

endpackage

// File: rtl/dpk_ptr.sv
// Data pointer with mode-dependent advance and wrap detection.
// Assumes the caller never asserts adv in the same cycle as load.
module dpk_ptr #(
    parameter int COLS  = 60,
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             adv,
    input  logic [3:0]       step,
    output logic [PTR_W-1:0] ptr,
    output logic             wrap_now,
    output logic             ovf
);
    localparam logic [PTR_W:0] LIMIT = (PTR_W+1)'(COLS);

    logic [PTR_W:0] sum;

    // Next position and wrap test for an advancing byte.
    always_comb begin
        sum      = {1'b0, ptr} + (PTR_W+1)'(step);
        wrap_now = adv && (sum >= LIMIT);
    end

    // Pointer register and one-cycle wrap pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            ovf <= 1'b0;
        end else begin
            ovf <= wrap_now;
            if (abort)         ptr <= '0;
            else if (load)     ptr <= load_val;
            else if (wrap_now) ptr <= '0;
            else if (adv)      ptr <= sum[PTR_W-1:0];
        end
    end
endmodule

// File: rtl/dpk_subsel.sv
// Cascade subaddress counter and match against the strapped subaddress.
// Assumes load and inc are never both asserted in one cycle.
module dpk_subsel #(
    parameter int SUB_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SUB_W-1:0] load_val,
    input  logic             inc,
    input  logic [SUB_W-1:0] hw_sub,
    output logic [SUB_W-1:0] cnt,
    output logic             match
);
    // Current counter compared with the hardware subaddress.
    assign match = (cnt == hw_sub);

    // Counter loaded by device select and stepped on pointer wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= load_val;
        else if (inc)  cnt <= cnt + SUB_W'(1);
    end
endmodule

// File: rtl/dpk_bitram.sv
// Bit-addressable display RAM. Each cell works out on its own whether the
// current byte lands on it, and if so which byte bit it takes.
// Assumes bpc is 1..4 and row_base is 0 or 2.
module dpk_bitram
    import dpk_pkg::*;
#(
    parameter int COLS  = 60,
    parameter int PTR_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [PTR_W-1:0]          base_ptr,
    input  logic [7:0]                data,
    input  logic [2:0]                bpc,
    input  logic [1:0]                row_base,
    input  logic [PTR_W-1:0]          rd_col,
    output logic [ROWS-1:0]           rd_data,
    output logic [COLS-1:0][ROWS-1:0] mem_q
);
    logic [ROWS-1:0] rd_nxt;

    for (genvar c = 0; c < COLS; c++) begin : g_col
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            logic       hit;
            logic [2:0] bsel;
            logic       bit_q;

            // Offset of this cell inside the byte's span and its bit index.
            always_comb begin
                int off;
                int rel;
                int idx;
                off  = c - int'(base_ptr);
                rel  = r - int'(row_base);
                idx  = off * int'(bpc) + rel;
                hit  = (off >= 0) && (rel >= 0) && (rel < int'(bpc)) && (idx < 8);
                bsel = 3'(7 - idx);
            end

            // Cell storage.
            always_ff @(posedge clk) begin
                if (!rst_n)            bit_q <= 1'b0;
                else if (wr_en && hit) bit_q <= data[bsel];
            end

            assign mem_q[c][r] = bit_q;
        end
    end

    // Column select for the display-side read.
    always_comb begin
        rd_nxt = '0;
        for (int c = 0; c < COLS; c++) begin
            if (int'(rd_col) == c) rd_nxt = mem_q[c];
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_nxt;
    end
endmodule

// File: rtl/dispram_packer.sv
// Top of the display RAM write packer. It decodes the drive mode into a
// column width and a pointer step, gates writes on the cascade match, and
// ties together the pointer, the subaddress counter and the bit RAM.
// Assumes that commands take priority over a byte strobe in the same cycle.
module dispram_packer
    import dpk_pkg::*;
#(
    parameter int COLS  = 60,
    parameter int PTR_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             byte_vld,
    input  logic [7:0]       byte_data,
    input  logic             ptr_load,
    input  logic [PTR_W-1:0] ptr_value,
    input  logic             sel_load,
    input  logic [2:0]       sel_value,
    input  logic             bank_in,
    input  logic [2:0]       hw_sub,
    input  logic             abort,
    input  logic [PTR_W-1:0] rd_col,
    output logic [3:0]       rd_data,
    output logic             ovf
);
    mux_mode_e                 mmode;
    logic                      accept;
    logic                      match;
    logic                      wr_en;
    logic                      wrap_now;
    logic [3:0]                step;
    logic [2:0]                bpc;
    logic [1:0]                row_base;
    logic [PTR_W-1:0]          ptr;
    logic [2:0]                sub_cnt;
    logic [COLS-1:0][ROWS-1:0] mem_q;

    // Mode decode, bank row choice and write qualification.
    always_comb begin
        mmode    = mux_mode_e'(mode);
        step     = cols_per_byte(mmode);
        bpc      = bits_per_col(mmode);
        row_base = (bank_in && (mmode == MUX_STATIC || mmode == MUX_DUAL)) ? 2'd2 : 2'd0;
        accept   = byte_vld && !ptr_load && !sel_load && !abort;
        wr_en    = accept && match;
    end

    dpk_ptr #(.COLS(COLS), .PTR_W(PTR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (abort),
        .load     (ptr_load),
        .load_val (ptr_value),
        .adv      (accept),
        .step     (step),
        .ptr      (ptr),
        .wrap_now (wrap_now),
        .ovf      (ovf)
    );

    dpk_subsel #(.SUB_W(3)) u_sub (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sel_load),
        .load_val (sel_value),
        .inc      (wrap_now),
        .hw_sub   (hw_sub),
        .cnt      (sub_cnt),
        .match    (match)
    );

    dpk_bitram #(.COLS(COLS), .PTR_W(PTR_W)) u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .base_ptr (ptr),
        .data     (byte_data),
        .bpc      (bpc),
        .row_base (row_base),
        .rd_col   (rd_col),
        .rd_data  (rd_data),
        .mem_q    (mem_q)
    );
endmodule

// File: rtl/dispram_packer_chk.sv
// Property checker for the display RAM write packer, bound to every instance.
// Assumes a synchronous active-low reset.
module dispram_packer_chk #(
    parameter int COLS  = 60,
    parameter int PTR_W = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  accept,
    input logic                  match,
    input logic                  wrap_now,
    input logic [3:0]            step,
    input logic [PTR_W-1:0]      ptr,
    input logic [2:0]            sub_cnt,
    input logic                  ovf,
    input logic                  ptr_load,
    input logic [PTR_W-1:0]      ptr_value,
    input logic                  abort,
    input logic [COLS*4-1:0]     mem_flat
);
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !wrap_now |=> ptr == PTR_W'($past(ptr) + PTR_W'($past(step)))); // R6
    AST_SKIP_KEEPS_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !match |=> $stable(mem_flat)); // R6
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> ptr == '0); // R7
    AST_SUB_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> sub_cnt == 3'($past(sub_cnt) + 3'd1)); // R7
    AST_PTR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load && !abort |=> ptr == $past(ptr_value)); // R8
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> ptr == '0); // R10
endmodule

bind dispram_packer dispram_packer_chk #(.COLS(COLS), .PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .match     (match),
    .wrap_now  (wrap_now),
    .step      (step),
    .ptr       (ptr),
    .sub_cnt   (sub_cnt),
    .ovf       (ovf),
    .ptr_load  (ptr_load),
    .ptr_value (ptr_value),
    .abort     (abort),
    .mem_flat  (mem_q)
);

// File: tb/tb_dispram_packer.sv
// Bench for the display RAM write packer: a behavioural reference model is
// updated on each rising edge and compared with the outputs on each falling edge.
module tb_dispram_packer;
    localparam int COLS  = 60;
    localparam int PTR_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       mode = 2'd0;
    logic             byte_vld = 1'b0;
    logic [7:0]       byte_data = 8'h00;
    logic             ptr_load = 1'b0;
    logic [PTR_W-1:0] ptr_value = '0;
    logic             sel_load = 1'b0;
    logic [2:0]       sel_value = 3'd0;
    logic             bank_in = 1'b0;
    logic [2:0]       hw_sub = 3'd0;
    logic             abort = 1'b0;
    logic [PTR_W-1:0] rd_col = '0;
    logic [3:0]       rd_data;
    logic             ovf;

    dispram_packer #(.COLS(COLS), .PTR_W(PTR_W)) dut (.*);

    always #2.5 clk = ~clk;

    int    mram [COLS][4];
    int    mptr, msub;
    int    exp_rd, exp_ovf;
    int    n_vec = 0, n_bad = 0, cycles = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // Reference model: follows the requirements text, updated at each rising edge.
    always @(posedge clk) begin
        int w, n, base, col, row, rc;
        if (!rst_n) begin
            foreach (mram[c, r]) mram[c][r] = 0;
            mptr = 0; msub = 0; exp_rd = 0; exp_ovf = 0;
        end else begin
            rc = int'(rd_col);
            exp_rd = 0;
            if (rc < COLS)
                for (int r = 0; r < 4; r++) exp_rd += mram[rc][r] << r;
            exp_ovf = 0;
            if (abort) mptr = 0;
            else if (ptr_load) mptr = int'(ptr_value);
            if (sel_load) msub = int'(sel_value);
            if (byte_vld && !ptr_load && !sel_load && !abort) begin
                w = int'(mode) + 1;
                n = (mode == 2'd0) ? 8 : (mode == 2'd1) ? 4 : (mode == 2'd2) ? 3 : 2;
                base = (bank_in && mode < 2'd2) ? 2 : 0;
                if (msub == int'(hw_sub)) begin
                    for (int b = 0; b < 8; b++) begin
                        col = mptr + b / w;
                        row = base + b % w;
                        if (col < COLS) mram[col][row] = int'(byte_data[7-b]);
                    end
                end
                if (mptr + n >= COLS) begin
                    mptr = 0; msub = (msub + 1) % 8; exp_ovf = 1;
                end else mptr = mptr + n;
            end
        end
    end

    // Comparison on every falling edge, plus the watchdog.
    always @(negedge clk) begin
        cycles++;
        n_vec += 2;
        if (int'(rd_data) != exp_rd) begin
            n_bad++;
            $display("FAIL %s rd_data col %0d: got %0h expected %0h", cur_req, rd_col, rd_data, exp_rd);
        end
        if (int'(ovf) != exp_ovf) begin
            n_bad++;
            $display("FAIL %s ovf: got %0d expected %0d", cur_req, ovf, exp_ovf);
        end
        if (cycles > 20000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic tick(int k = 1);
        repeat (k) @(negedge clk);
    endtask

    task automatic put_byte(logic [7:0] d);
        byte_vld = 1'b1; byte_data = d; tick(); byte_vld = 1'b0;
    endtask

    task automatic load_ptr(int v);
        ptr_load = 1'b1; ptr_value = PTR_W'(v); tick(); ptr_load = 1'b0;
    endtask

    task automatic select(int v);
        sel_load = 1'b1; sel_value = 3'(v); tick(); sel_load = 1'b0;
    endtask

    task automatic sweep();
        for (int c = 0; c < 64; c++) begin
            rd_col = PTR_W'(c); tick();
        end
        tick(2);
    endtask

    initial begin
        tick(4);
        cur_req = "R1"; rst_n = 1'b1; sweep();

        cur_req = "R2"; mode = 2'd0; load_ptr(5); put_byte(8'hA5); put_byte(8'h3C); sweep();

        cur_req = "R9"; bank_in = 1'b1; load_ptr(20); put_byte(8'hF0); sweep();

        cur_req = "R3"; bank_in = 1'b0; mode = 2'd1; load_ptr(30); put_byte(8'h96); put_byte(8'h5A); sweep();
        cur_req = "R9"; bank_in = 1'b1; put_byte(8'hC3); bank_in = 1'b0; sweep();

        // Column 42 row 2 is preset to 1 and must survive the 1:3 byte.
        cur_req = "R4"; mode = 2'd3; load_ptr(42); put_byte(8'hFF);
        mode = 2'd2; bank_in = 1'b1; load_ptr(40); put_byte(8'h00); put_byte(8'hB6);
        bank_in = 1'b0; sweep();

        cur_req = "R5"; mode = 2'd3; load_ptr(50); put_byte(8'h69); put_byte(8'h1E); sweep();

        cur_req = "R6"; hw_sub = 3'd1; select(3); mode = 2'd0; load_ptr(10);
        put_byte(8'hFF); put_byte(8'hFF); select(1); put_byte(8'h81); sweep();

        cur_req = "R7"; hw_sub = 3'd2; mode = 2'd0; load_ptr(56); put_byte(8'hFF);
        put_byte(8'h5A); tick(2);
        mode = 2'd2; load_ptr(57); put_byte(8'h6D); tick();
        mode = 2'd3; select(3); hw_sub = 3'd3; load_ptr(59); put_byte(8'hAA);
        load_ptr(62); put_byte(8'h77); tick(); sweep();

        cur_req = "R8"; hw_sub = 3'd0; select(0); mode = 2'd0; load_ptr(16);
        byte_vld = 1'b1; byte_data = 8'hFF; ptr_load = 1'b1; ptr_value = PTR_W'(24); tick();
        ptr_load = 1'b0; sel_load = 1'b1; sel_value = 3'd0; tick();
        sel_load = 1'b0; byte_vld = 1'b0; put_byte(8'h0F); sweep();

        cur_req = "R10"; load_ptr(12); mode = 2'd1;
        byte_vld = 1'b1; byte_data = 8'hEE; abort = 1'b1; ptr_load = 1'b1; ptr_value = PTR_W'(33); tick();
        byte_vld = 1'b0; abort = 1'b0; ptr_load = 1'b0; put_byte(8'h3C); sweep();

        cur_req = "R11"; rd_col = PTR_W'(0); load_ptr(0); mode = 2'd3; put_byte(8'h5A); tick(4);
        rd_col = PTR_W'(1); tick(3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule